// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block takes the four active-low PCI interrupt request pins, labelled A to D, and steers each one onto one of sixteen request lines that feed an ISA-compatible interrupt controller. Every pin has its own 4-bit line selector and its own trigger-mode bit. The selector code space is sparse: most codes name the line of the same number, and a few codes route the pin nowhere. A pin in level mode drives its line high for as long as the pin is held low. A pin in edge mode turns each falling edge into a single-clock high pulse, which the controller sees as a rising edge.

Each pin also has a companion request that arrives over the serial interrupt path. That request is steered by the same selector as its pin. It is blocked while the pin is in edge mode. All requests that land on the same line are ORed together. The pins are asynchronous and pass through a two-flop synchronizer before any use. Software programs the mode bits and the selectors through a small byte-wide register port with single-cycle writes and a combinational read.

Top module: `pirq_router`

## Requirements
- R1: After reset, every register byte reads 0 and all sixteen request lines are low.
- R2: Byte address 0 holds the mode bits, with pin A in bit 0, B in bit 1, C in bit 2 and D in bit 3. Bits 7:4 always read 0, whatever value is written to them.
- R3: The selectors form a 16-bit value with A in bits 3:0, B in 7:4, C in 11:8 and D in 15:12. Byte address 1 holds bits 7:0 and byte address 2 holds bits 15:8. Byte address 3 always reads 0, and a write to it changes nothing.
- R4: Selector codes 1, 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15 steer the pin's request to the line with the same number.
- R5: Selector codes 0, 2, 8 and 13 steer the request to no line. Lines 0, 2, 8 and 13 are therefore never driven.
- R6: In level mode (mode bit 0), the routed line is high while the synchronised pin is low. A pin change that is set up before clock edge k shows at the output after edge k+1.
- R7: In edge mode (mode bit 1), each falling edge on the pin drives the routed line high for exactly one clock, in the cycle that follows edge k+1. The line stays low while the pin is held low or high.
- R8: The serial request of a pin is steered by that pin's selector, without a clock of delay, only while the pin's mode bit is 0. While the mode bit is 1, the serial request has no effect.
- R9: When several requests (pins or serial requests) select the same line, that line is the OR of all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinN | input | 4 | Asynchronous active-low interrupt pins, A in bit 0 to D in bit 3 |
| serReq | input | 4 | Serial-path interrupt requests per pin, active high, synchronous |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register byte address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| irqOut | output | 16 | Active-high request lines to the interrupt controller |

## Verification
Each of the sixteen selector codes is tried with a single pin held low. This separates the routed codes from the silent ones. Level pulses and edge pulses of several lengths separate the two modes: a long low pin gives a held line in level mode and one single-clock pulse in edge mode. The serial requests are toggled under both mode settings, which shows that the gate follows the mode bit. Finally all four pins, and then mixed pin and serial requests, share one line, which exercises the OR merge and the shared-line behaviour.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned PinCount   = 4;
  localparam int unsigned LineCount  = 16;
  localparam int unsigned SelW       = $clog2(LineCount);
  localparam int unsigned RouteW     = PinCount * SelW;
  localparam int unsigned ByteW      = 8;
  localparam int unsigned RouteBytes = RouteW / ByteW;
  localparam int unsigned AddrW      = 2;
  // set bit n => selector code n steers to line n
  localparam logic [LineCount-1:0] LegalMask = 16'hDEFA;

  typedef struct packed {
    logic                  wrMode;
    logic [RouteBytes-1:0] wrRoute;
    logic [ByteW-1:0]      data;
  } regStrobe_t;
endpackage

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [AddrW-1:0]     regAddr,
  input  logic [ByteW-1:0]     regWrData,
  input  logic [PinCount-1:0]  modeBits,
  input  logic [RouteW-1:0]    routeBits,
  output regStrobe_t           strobe,
  output logic [ByteW-1:0]     regRdData
);
  localparam logic [ByteW-PinCount-1:0] PadZero = '0;

  always_comb begin
    strobe.data   = regWrData;
    strobe.wrMode = regWrEn && (regAddr == AddrW'(0));
  end

  generate
    for (genvar b = 0; b < RouteBytes; b++) begin : g_wr
      assign strobe.wrRoute[b] = regWrEn && (regAddr == AddrW'(b + 1));
    end
  endgenerate

  always_comb begin
    regRdData = '0;
    if (regAddr == AddrW'(0)) regRdData = {PadZero, modeBits};
    for (int b = 0; b < RouteBytes; b++)
      if (regAddr == AddrW'(b + 1)) regRdData = routeBits[b*ByteW +: ByteW];
  end

  // R2: reserved mode-byte bits never read back as 1
  a_r2_mode_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == AddrW'(0)) |-> (regRdData[ByteW-1:PinCount] == '0));
endmodule

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PinCount-1:0]  pinN,
  input  logic [PinCount-1:0]  serReq,
  input  regStrobe_t           strobe,
  output logic [PinCount-1:0]  modeBits,
  output logic [RouteW-1:0]    routeBits,
  output logic [LineCount-1:0] irqOut
);
  logic [PinCount-1:0] syncA, syncB, syncPrev;
  logic [PinCount-1:0] pinReq, anyReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= '1;
      syncB    <= '1;
      syncPrev <= '1;
    end else begin
      syncA    <= pinN;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeBits <= '0;
    else if (strobe.wrMode) modeBits <= strobe.data[PinCount-1:0];
  end

  generate
    for (genvar b = 0; b < RouteBytes; b++) begin : g_route
      always_ff @(posedge clk) begin
        if (!rstN) routeBits[b*ByteW +: ByteW] <= '0;
        else if (strobe.wrRoute[b]) routeBits[b*ByteW +: ByteW] <= strobe.data;
      end
    end

    for (genvar p = 0; p < PinCount; p++) begin : g_pin
      logic [SelW-1:0] code;
      assign code      = routeBits[p*SelW +: SelW];
      assign pinReq[p] = modeBits[p] ? (syncPrev[p] && !syncB[p]) : !syncB[p];
      assign anyReq[p] = pinReq[p] || (serReq[p] && !modeBits[p]);

      // R6: level-mode low pin with a legal selector holds its line high
      a_r6_level_drives: assert property (@(posedge clk) disable iff (!rstN)
        (!modeBits[p] && !syncB[p] && LegalMask[code]) |-> irqOut[code]);
      // R7: an edge-mode pulse never lasts more than one clock
      a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
        (modeBits[p] && pinReq[p]) |=> !(modeBits[p] && pinReq[p]));
    end
  endgenerate

  always_comb begin
    irqOut = '0;
    for (int p = 0; p < PinCount; p++) begin
      if (LegalMask[routeBits[p*SelW +: SelW]] && anyReq[p])
        irqOut[routeBits[p*SelW +: SelW]] = 1'b1;
    end
  end

  // R5: lines without a legal selector code stay silent
  a_r5_silent_lines: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOut & ~LegalMask) == '0));
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PinCount-1:0]  pinN,
  input  logic [PinCount-1:0]  serReq,
  input  logic                 regWrEn,
  input  logic [AddrW-1:0]     regAddr,
  input  logic [ByteW-1:0]     regWrData,
  output logic [ByteW-1:0]     regRdData,
  output logic [LineCount-1:0] irqOut
);
  regStrobe_t          strobe;
  logic [PinCount-1:0] modeBits;
  logic [RouteW-1:0]   routeBits;

  pirq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .modeBits(modeBits), .routeBits(routeBits),
    .strobe(strobe), .regRdData(regRdData)
  );

  pirq_datapath dp_i (
    .clk(clk), .rstN(rstN), .pinN(pinN), .serReq(serReq), .strobe(strobe),
    .modeBits(modeBits), .routeBits(routeBits), .irqOut(irqOut)
  );

  // R1: nothing requested in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> (irqOut == '0));
endmodule

// File: tb/pirq_router_tb_top.sv
`timescale 1ns/1ps
module pirq_router_tb_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  pinN = 4'hF;
  logic [3:0]  serReq = 4'h0;
  logic        regWrEn = 0;
  logic [1:0]  regAddr = 0;
  logic [7:0]  regWrData = 0;
  logic [7:0]  regRdData;
  logic [15:0] irqOut;

  int errors = 0;
  int checks = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  pirq_router dut_i (.*);

  // behavioural reference state
  logic [3:0]  mMode;
  logic [15:0] mRoute;
  logic [3:0]  h1, h2, h3;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mRoute = 0; h1 = 4'hF; h2 = 4'hF; h3 = 4'hF;
    end else begin
      h3 = h2; h2 = h1; h1 = pinN;
      if (regWrEn) begin
        case (regAddr)
          2'd0: mMode = regWrData[3:0];
          2'd1: mRoute[7:0] = regWrData;
          2'd2: mRoute[15:8] = regWrData;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] expIrq();
    logic [15:0] e = 0;
    for (int p = 0; p < 4; p++) begin
      int code = mRoute[p*4 +: 4];
      bit req = mMode[p] ? (h3[p] && !h2[p]) : !h2[p];
      if (!mMode[p] && serReq[p]) req = 1;
      if (req && (code inside {1,3,4,5,6,7,9,10,11,12,14,15})) e[code] = 1;
    end
    return e;
  endfunction

  function automatic logic [7:0] expRd();
    case (regAddr)
      2'd0: return {4'h0, mMode};
      2'd1: return mRoute[7:0];
      2'd2: return mRoute[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check({curReq, " irq"}, irqOut, expIrq());
    check({curReq, " rd"}, {8'h0, regRdData}, {8'h0, expRd()});
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    step(1);
    regWrEn = 0;
  endtask

  initial begin : watchdog
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1;
    step(1);
    curReq = "R1";
    for (int a = 0; a < 4; a++) begin
      regAddr = a[1:0]; #1;
      check("R1 reset byte", {8'h0, regRdData}, 16'h0);
    end
    check("R1 reset lines", irqOut, 16'h0);

    curReq = "R2";
    wr(0, 8'hFF); regAddr = 0; #1;
    check("R2 upper bits", {8'h0, regRdData}, 16'h000F);
    wr(0, 8'hA5); regAddr = 0; #1;
    check("R2 pattern", {8'h0, regRdData}, 16'h0005);
    wr(0, 8'h00);

    curReq = "R3";
    wr(1, 8'h43); wr(2, 8'hC9);
    regAddr = 1; #1; check("R3 low byte", {8'h0, regRdData}, 16'h0043);
    regAddr = 2; #1; check("R3 high byte", {8'h0, regRdData}, 16'h00C9);
    wr(3, 8'h77); regAddr = 3; #1; check("R3 addr3", {8'h0, regRdData}, 16'h0);
    regAddr = 1; #1; check("R3 unchanged", {8'h0, regRdData}, 16'h0043);

    // R4/R5: every code on pin A, level mode
    wr(1, 8'h00); wr(2, 8'h00);
    for (int c = 0; c < 16; c++) begin
      curReq = (c inside {0,2,8,13}) ? "R5" : "R4";
      wr(1, c[7:0]);
      pinN = 4'b1110; step(3);
      if (c inside {0,2,8,13}) check("R5 silent", irqOut, 16'h0);
      else check("R4 routed", irqOut, 16'h1 << c);
      pinN = 4'hF; step(3);
    end

    curReq = "R6";
    wr(1, 8'h50); wr(2, 8'h00); // A->0? B->5
    pinN = 4'b1101; step(1);
    check("R6 not yet", irqOut, 16'h0);
    step(1);
    check("R6 after sync", irqOut, 16'h0020);
    step(6);
    pinN = 4'hF; step(3);

    curReq = "R7";
    wr(0, 8'h02);
    pinN = 4'b1101; step(2);
    check("R7 pulse", irqOut, 16'h0020);
    step(1);
    check("R7 pulse ends", irqOut, 16'h0);
    step(5);
    pinN = 4'hF; step(3);
    pinN = 4'b1101; step(1); pinN = 4'hF; step(5);

    curReq = "R8";
    serReq = 4'b0010; step(1);
    check("R8 blocked", irqOut, 16'h0);
    wr(0, 8'h00); #1;
    check("R8 passes", irqOut, 16'h0020);
    serReq = 4'b0001; #1;
    check("R8 code0 pin A", irqOut, 16'h0);
    serReq = 0; step(2);

    curReq = "R9";
    wr(1, 8'h77); wr(2, 8'h77);
    pinN = 4'b0101; step(4);
    check("R9 shared", irqOut, 16'h0080);
    pinN = 4'b0111; serReq = 4'b1000; step(4);
    pinN = 4'hF; step(3);
    serReq = 0;
    wr(0, 8'h0F);
    for (int k = 0; k < 4; k++) begin
      pinN = ~(4'b1 << k); step(2); pinN = 4'hF; step(3);
    end
    pinN = 4'b0000; step(6); pinN = 4'hF; step(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule